// File: doc/BRIEF.md
# MDIO Management Controller

This block lets software run PHY management transactions through two 32-bit registers on a simple register bus. A control register holds the target PHY number, the register number inside that PHY, a divider range, a write flag and a busy flag. A data register holds the value to send on a write, or the value returned by a read.

To write a PHY register, software first loads the data register. It then writes the control register with the busy flag set. For a read, software writes the control register with busy set and the write flag clear. The controller builds one standard 64-bit management frame, shifts it out on MDIO with a derived MDC clock, and clears busy by itself when the frame ends. After a read, the captured data is in the data register. While busy is set, bus writes to either register are ignored. The MDIO pad is split into separate output, output-enable and input signals.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset, both registers read 0, MDC is low and the MDIO output enable is low.
- R2: Control register layout: bit 0 is busy, bit 1 is write, bits [4:2] are the divider range, bits [9:5] are the register number and bits [14:10] are the PHY number. Writing this register with bit 0 set while idle starts a transaction, and busy then reads 1. Busy clears only when the frame completes. A write with bit 0 clear only updates the fields, and MDC stays low.
- R3: Each frame is 64 MDC bits, MSB first: 32 ones, then 01, then the opcode (10 for a read, 01 for a write), the 5-bit PHY number, the 5-bit register number, a 2-bit turnaround and 16 data bits.
- R4: On a write, the turnaround is driven as 10, the last 16 bits are data register bits [15:0], and the output enable stays high for all 64 bits.
- R5: On a read, the output enable is high for bits 0 to 45 and low for bits 46 to 63. MDIO is sampled on each rising MDC edge of bits 48 to 63, and the 16 sampled bits appear in data register bits [15:0] when busy clears.
- R6: MDC is low while idle. While busy, each MDC half period lasts 2^(range+1) clock cycles.
- R7: Bus writes to either register while busy change neither the register contents nor the frame in progress.
- R8: The MDIO output changes only on falling MDC edges, so it is stable at every rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 control, 1 data |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Some properties are checked on every cycle:
- MDC is low whenever busy is clear.
- The MDIO output holds steady across each rising MDC edge.
- The register fields stay frozen while busy is set.
- Busy falls only on the cycle that follows frame completion.
- A finished read copies the captured bits into the data register.

Other behaviour only the bench scenarios can show. These are the exact bit sequence of each frame, the output-enable pattern, and the MDC period for each divider range. They also include the round trip of read data from a PHY model, and the fact that writes poked in mid-frame leave the frame and the register readback untouched.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W     = 5;
  localparam int REGN_W    = 5;
  localparam int DATA_W    = 16;
  localparam int FRAME_LEN = 64;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TA_POS    = 46;  // first turnaround bit
  localparam int DATA_POS  = 48;  // first data bit

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic              is_wr,
    input logic [PHY_W-1:0]  phy,
    input logic [REGN_W-1:0] regn,
    input logic [DATA_W-1:0] data
  );
    logic [1:0]        op;
    logic [1:0]        ta;
    logic [DATA_W-1:0] payload;
    op      = is_wr ? OP_WRITE : OP_READ;
    ta      = is_wr ? 2'b10 : 2'b00;
    payload = is_wr ? data : '0;
    return {32'hFFFF_FFFF, 2'b01, op, phy, regn, ta, payload};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int RANGE_W = 3,
  parameter int CNT_W   = (1 << RANGE_W) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [RANGE_W-1:0] rng,
  output logic               mdc,
  output logic               rise,
  output logic               fall
);
  logic [CNT_W-1:0] cnt_q, cnt_d, half_m1;
  logic [RANGE_W:0] shamt;
  logic             mdc_q, mdc_d, terminal;

  always_comb begin
    shamt    = {1'b0, rng} + 1'b1;
    half_m1  = (CNT_W'(1) << shamt) - CNT_W'(1);
    terminal = en && (cnt_q == half_m1);
    if (!en) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (terminal) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
      mdc_d = mdc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc  = mdc_q;
  assign rise = terminal & ~mdc_q;
  assign fall = terminal & mdc_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= half_m1)); // R6
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [FRAME_LEN-1:0] frame,
  input  logic                 is_wr,
  input  logic                 rise,
  input  logic                 fall,
  input  logic                 mdio_i,
  output logic                 active,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 done,
  output logic [DATA_W-1:0]    rx_data
);
  logic                 active_q, active_d, wr_q, wr_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [FRAME_LEN-1:0] tx_q, tx_d;
  logic [DATA_W-1:0]    rx_q, rx_d;
  logic                 last_bit;

  assign last_bit = (idx_q == IDX_W'(FRAME_LEN - 1));
  assign done     = active_q & fall & last_bit;

  always_comb begin
    active_d = active_q;
    wr_d     = wr_q;
    idx_d    = idx_q;
    tx_d     = tx_q;
    rx_d     = rx_q;
    if (start) begin
      active_d = 1'b1;
      wr_d     = is_wr;
      idx_d    = '0;
      tx_d     = frame;
      rx_d     = '0;
    end else if (active_q) begin
      if (rise && !wr_q && idx_q >= IDX_W'(DATA_POS))
        rx_d = {rx_q[DATA_W-2:0], mdio_i};
      if (fall) begin
        if (last_bit) active_d = 1'b0;
        else begin
          idx_d = idx_q + 1'b1;
          tx_d  = {tx_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      idx_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      active_q <= active_d;
      wr_q     <= wr_d;
      idx_q    <= idx_d;
      tx_q     <= tx_d;
      rx_q     <= rx_d;
    end
  end

  assign active  = active_q;
  assign mdio_o  = active_q & tx_q[FRAME_LEN-1];
  assign mdio_oe = active_q & (wr_q | (idx_q < IDX_W'(TA_POS)));
  assign rx_data = rx_q;

  AST_TX_HOLD_BETWEEN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !fall) |=> $stable(tx_q)); // R8
  AST_WRITE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && wr_q) |=> $stable(rx_q)); // R4
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
  import mdio_pkg::*;
#(
  parameter int RANGE_W = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic        bus_sel,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int BUSY_B  = 0;
  localparam int WR_B    = 1;
  localparam int RNG_LSB = 2;
  localparam int REG_LSB = RNG_LSB + RANGE_W;
  localparam int PHY_LSB = REG_LSB + REGN_W;
  localparam int CTRL_W  = PHY_LSB + PHY_W;
  localparam int CNT_W   = (1 << RANGE_W) + 1;

  logic               busy_q, busy_d, wr_q, wr_d;
  logic [RANGE_W-1:0] rng_q, rng_d;
  logic [REGN_W-1:0]  regn_q, regn_d;
  logic [PHY_W-1:0]   phy_q, phy_d;
  logic [DATA_W-1:0]  data_q, data_d;
  logic               ctrl_wr, data_wr, start;
  logic               active, done, rise, fall;
  logic [DATA_W-1:0]  rx_data;
  logic [FRAME_LEN-1:0] frame;

  assign ctrl_wr = bus_we & ~bus_sel;
  assign data_wr = bus_we & bus_sel;
  assign start   = ctrl_wr & ~busy_q & bus_wdata[BUSY_B];
  assign frame   = build_frame(bus_wdata[WR_B], bus_wdata[PHY_LSB +: PHY_W],
                               bus_wdata[REG_LSB +: REGN_W], data_q);

  always_comb begin
    busy_d = busy_q;
    wr_d   = wr_q;
    rng_d  = rng_q;
    regn_d = regn_q;
    phy_d  = phy_q;
    data_d = data_q;
    if (!busy_q) begin
      if (ctrl_wr) begin
        busy_d = bus_wdata[BUSY_B];
        wr_d   = bus_wdata[WR_B];
        rng_d  = bus_wdata[RNG_LSB +: RANGE_W];
        regn_d = bus_wdata[REG_LSB +: REGN_W];
        phy_d  = bus_wdata[PHY_LSB +: PHY_W];
      end
      if (data_wr) data_d = bus_wdata[DATA_W-1:0];
    end else if (done) begin
      busy_d = 1'b0;
      if (!wr_q) data_d = rx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      rng_q  <= '0;
      regn_q <= '0;
      phy_q  <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      wr_q   <= wr_d;
      rng_q  <= rng_d;
      regn_q <= regn_d;
      phy_q  <= phy_d;
      data_q <= data_d;
    end
  end

  assign bus_rdata = bus_sel ? 32'(data_q)
                             : 32'({phy_q, regn_q, rng_q, wr_q, busy_q});

  mdio_clkdiv #(.RANGE_W(RANGE_W), .CNT_W(CNT_W)) u_clkdiv (
    .clk(clk), .rst_n(rst_n), .en(active), .rng(rng_q),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame u_frame (
    .clk(clk), .rst_n(rst_n), .start(start), .frame(frame),
    .is_wr(bus_wdata[WR_B]), .rise(rise), .fall(fall), .mdio_i(mdio_i),
    .active(active), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done),
    .rx_data(rx_data)
  );

  localparam int UNUSED_W = 32 - CTRL_W;
  if (UNUSED_W < 0) begin : g_bad_width
    $error("control fields exceed the register width");
  end

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdc); // R6
  AST_OUT_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $stable(mdio_o)); // R8
  AST_BUSY_CLEAR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(done)); // R2
  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable({phy_q, regn_q, rng_q, wr_q})); // R7
  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> $stable(data_q)); // R7
  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_q) |=> (data_q == $past(rx_data))); // R5
endmodule

// File: tb/mdio_mgmt_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we, bus_sel;
  logic [31:0] bus_wdata, bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        mon_clr;
  logic [15:0] phy_val;
  logic [63:0] obits, oebits;
  int          nbits;
  time         t_first, t_second;
  int          errors = 0;
  int          checks = 0;

  always #10 clk = ~clk;

  mdio_mgmt u_mdio_mgmt (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // line monitor: records each bit at rising MDC
  always @(posedge mdc or posedge mon_clr) begin
    if (mon_clr) nbits = 0;
    else if (nbits < 64) begin
      obits[63-nbits]  = mdio_o;
      oebits[63-nbits] = mdio_oe;
      nbits = nbits + 1;
      if (nbits == 1) t_first = $time;
      if (nbits == 2) t_second = $time;
    end
  end

  // PHY model: presents read data after falling MDC
  always @(negedge mdc or posedge mon_clr) begin
    if (mon_clr) mdio_i = 1'b1;
    else if (nbits >= 48 && nbits < 64) mdio_i = phy_val[63-nbits];
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input bit sel, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input bit sel, output logic [31:0] d);
    @(negedge clk);
    bus_sel = sel;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(bit wr, logic [4:0] phy,
      logic [4:0] rg, logic [2:0] rng, bit busy);
    return 32'({phy, rg, rng, wr, busy});
  endfunction

  function automatic logic [63:0] exp_frame(bit wr, logic [4:0] phy,
      logic [4:0] rg, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
            (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0)};
  endfunction

  task automatic run_txn(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [2:0] rng, input logic [15:0] wd,
                         input logic [15:0] rv, input bit poke);
    logic [31:0] r;
    logic [63:0] mask, exp_oe;
    bit          finished = 0;
    phy_val = rv;
    mon_clr = 1'b1; #1 mon_clr = 1'b0;
    bus_write(1'b1, 32'(wd));
    bus_write(1'b0, ctrl_word(wr, phy, rg, rng, 1'b1));
    bus_read(1'b0, r);
    check(r[0] == 1'b1, "R2 busy set after start", 64'(r[0]), 64'd1);
    if (poke) begin
      bus_write(1'b1, 32'(~wd));
      bus_write(1'b0, ctrl_word(~wr, ~phy, ~rg, ~rng, 1'b1));
    end
    for (int i = 0; i < 40000; i++) begin
      bus_read(1'b0, r);
      if (!r[0]) begin finished = 1; break; end
    end
    check(finished, "R2 busy clears at end", 64'(finished), 64'd1);
    check(nbits == 64, "R3 frame bit count", 64'(nbits), 64'd64);
    mask   = wr ? '1 : {{46{1'b1}}, 18'h0};
    exp_oe = wr ? '1 : {{46{1'b1}}, 18'h0};
    check((obits & mask) == (exp_frame(wr, phy, rg, wd) & mask),
          wr ? "R4 write frame" : "R3 read frame",
          obits & mask, exp_frame(wr, phy, rg, wd) & mask);
    check(oebits == exp_oe, wr ? "R4 oe pattern" : "R5 oe pattern", oebits, exp_oe);
    check((t_second - t_first) == time'(2 * (2 << rng) * 20), "R6 mdc period",
          64'(t_second - t_first), 64'(2 * (2 << rng) * 20));
    bus_read(1'b1, r);
    check(r == 32'(wr ? wd : rv), poke ? "R7 data kept" : "R5 data register",
          64'(r), 64'(wr ? wd : rv));
    bus_read(1'b0, r);
    check(r == ctrl_word(wr, phy, rg, rng, 1'b0), "R7 control readback",
          64'(r), 64'(ctrl_word(wr, phy, rg, rng, 1'b0)));
  endtask

  task automatic main_seq();
    logic [31:0] r;
    int unused_seed;
    unused_seed = $urandom(32'h5EED);
    rst_n = 1'b0; bus_we = 1'b0; bus_sel = 1'b0; bus_wdata = '0;
    mon_clr = 1'b1; phy_val = '0;
    #1 mon_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    bus_read(1'b0, r); check(r == 0, "R1 control reset", 64'(r), 0);
    bus_read(1'b1, r); check(r == 0, "R1 data reset", 64'(r), 0);
    check(mdc == 0 && mdio_oe == 0, "R1 pins idle", 64'({mdc, mdio_oe}), 0);
    // R2 write without busy only updates fields
    bus_write(1'b0, ctrl_word(1'b1, 5'd9, 5'd3, 3'd1, 1'b0));
    repeat (100) @(posedge clk);
    bus_read(1'b0, r);
    check(r == ctrl_word(1'b1, 5'd9, 5'd3, 3'd1, 1'b0), "R2 no start",
          64'(r), 64'(ctrl_word(1'b1, 5'd9, 5'd3, 3'd1, 1'b0)));
    check(nbits == 0 && mdc == 0, "R6 mdc idle", 64'(nbits), 0);
    // directed corner cases
    run_txn(1'b1, 5'd31, 5'd31, 3'd0, 16'hFFFF, 16'h0000, 1'b0);
    run_txn(1'b0, 5'd0, 5'd0, 3'd3, 16'h0000, 16'hFFFF, 1'b0);
    run_txn(1'b0, 5'd17, 5'd5, 3'd0, 16'h1234, 16'hA5C3, 1'b1);
    run_txn(1'b1, 5'd2, 5'd30, 3'd1, 16'h8001, 16'h0000, 1'b1);
    // constrained random
    for (int k = 0; k < 12; k++)
      run_txn(1'($urandom), 5'($urandom), 5'($urandom), 3'($urandom % 3),
              16'($urandom), 16'($urandom), 1'($urandom));
  endtask

  initial begin
    bit timed_out = 0;
    fork
      main_seq();
      begin repeat (190000) @(posedge clk); timed_out = 1; end
    join_any
    disable fork;
    if (timed_out) check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule